// File: doc/BRIEF.md
# Dual-Style Host Register Port

This block is a slave register port. Through it a host processor reads and writes a small internal register file over an 8-bit data bus and a 7-bit address bus. A static strap input picks one of two host bus styles. In split-strobe style, a read strobe and a write strobe are used, both active low. In data-strobe style, a read/write level pin, an address strobe and a data strobe are used. The register file sits in the block. The block also produces a data-bus output enable for the pad ring and a ready indication timed from the host clock.

All host inputs pass through a two-flop synchronizer clocked by the host clock before they are decoded. A write takes effect when the synchronized write or data strobe rises. Read data is driven for as long as the synchronized read condition holds. When the block is not driving read data, the output enable is low, so the pads leave all eight lines high-impedance. The output value is also forced to zero at those times. Addresses at or above the implemented register count read as zero, and writes to them have no effect.

Top module: `host_reg_port`

## Requirements
- R1: With `ds_style`=0 (split strobes), while `rd_or_rw` is low the block drives `h_doe`=1 and places the register at `h_addr` on `h_dout`. Both appear after the second host-clock rising edge that follows the strobe falling.
- R2: With `ds_style`=0, the value on `h_din` is written into the register at `h_addr` when `wr_or_ds_n` rises. A later read returns that value.
- R3: With `ds_style`=1, `rd_or_rw` is a level pin: 1 selects a read and 0 selects a write.
- R4: With `ds_style`=1, the value on `h_din` is written into the register at `h_addr` when `wr_or_ds_n` rises while `astb_n`=0 and `rd_or_rw`=0.
- R5: With `ds_style`=1, the addressed register is driven while `astb_n`=0, `rd_or_rw`=1 and `wr_or_ds_n`=0. A data-strobe pulse while `astb_n`=1 neither drives the bus nor writes.
- R6: `h_doe` is 0 whenever no read is in progress, including during writes, and `h_dout` is then 0x00. After a read strobe is released, `h_doe` falls after the second host-clock rising edge.
- R7: `h_rdy` rises after the fourth host-clock rising edge that follows a strobe becoming active. That is two cycles after the synchronized strobe is seen. `h_rdy` falls after the second rising edge that follows the strobe release.
- R8: Addresses at or above `NUM_REGS` (default 32) read as 0x00, and writes to them are ignored.
- R9: After reset all implemented registers hold 0x00, and `h_doe` and `h_rdy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host clock; times synchronization, writes and ready |
| arst_n | input | 1 | Asynchronous active-low reset |
| ds_style | input | 1 | Static strap: 0 split strobes, 1 address/data strobe |
| h_addr | input | 7 | Register address |
| rd_or_rw | input | 1 | Read strobe (active low) in style 0; read/write level in style 1 |
| wr_or_ds_n | input | 1 | Write strobe in style 0; data strobe in style 1; active low |
| astb_n | input | 1 | Address strobe, active low, used in style 1 |
| h_din | input | 8 | Data from the host bus |
| h_dout | output | 8 | Read data toward the bus pads, 0 when not driving |
| h_doe | output | 1 | Pad output enable; 0 leaves the bus high-impedance |
| h_rdy | output | 1 | Ready indication |

## Verification
The bench targets the exact cycles of the ready rise and fall, the bus turn-on and the bus release. A design that skipped or doubled a synchronizer stage, or counted the ready delay from the wrong point, would miss those samples. It pulses the data strobe with the address strobe high, which a decoder ignoring the address strobe would turn into a write or a bus drive. It writes the last implemented address, the first unimplemented one and several far above it. An address decoder that aliased or truncated would then corrupt or return a live register. Random reads and writes in both styles are compared against a model, which catches a swapped read/write level or a write taken on the falling edge of the strobe.

// File: rtl/host_reg_pkg.sv
package host_reg_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;

  typedef logic [ADDR_W-1:0] haddr_t;
  typedef logic [DATA_W-1:0] hdata_t;

  typedef enum logic {
    STYLE_SPLIT   = 1'b0,
    STYLE_DSTROBE = 1'b1
  } bus_style_e;
endpackage

// File: rtl/host_sync.sv
module host_sync #(
  parameter int           WIDTH   = 1,
  parameter int           STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/host_strobe_decode.sv
module host_strobe_decode
  import host_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bus_style_e style,
  input  logic       rdrw_s,
  input  logic       wrds_s,
  input  logic       astb_s,
  output logic       rd_act,
  output logic       wr_act,
  output logic       wr_pulse
);
  logic wrds_q, wrds_d;
  logic strobe_rose;

  always_comb begin
    wrds_d = wrds_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wrds_q <= 1'b1;
    else        wrds_q <= wrds_d;
  end

  assign strobe_rose = ~wrds_q & wrds_s;

  always_comb begin
    rd_act   = 1'b0;
    wr_act   = 1'b0;
    wr_pulse = 1'b0;
    unique case (style)
      STYLE_SPLIT: begin
        rd_act   = ~rdrw_s;
        wr_act   = ~wrds_s;
        wr_pulse = strobe_rose;
      end
      STYLE_DSTROBE: begin
        rd_act   = ~astb_s &  rdrw_s & ~wrds_s;
        wr_act   = ~astb_s & ~rdrw_s & ~wrds_s;
        wr_pulse = ~astb_s & ~rdrw_s & strobe_rose;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/host_reg_file.sv
module host_reg_file
  import host_reg_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  haddr_t addr,
  input  hdata_t wdata,
  output hdata_t rdata
);
  hdata_t regs_q [NUM_REGS];
  logic   in_range;

  always_comb begin
    in_range = (int'(addr) < NUM_REGS);
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic   hit;
    hdata_t reg_d;

    always_comb begin
      hit   = wr_en && (int'(addr) == g);
      reg_d = hit ? wdata : regs_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_q[g] <= '0;
      else if (hit) regs_q[g] <= reg_d;
    end

    AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(addr) == g) |=> (regs_q[g] == $past(wdata))) else $error("write lost"); // R2

    AST_OOR_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(addr) >= NUM_REGS) |=> $stable(regs_q[g])) else $error("oor write"); // R8
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (in_range && int'(addr) == i) rdata = regs_q[i];
    end
  end
endmodule

// File: rtl/host_ready_gen.sv
module host_ready_gen #(
  parameter int RDY_DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  output logic rdy
);
  localparam int CW = $clog2(RDY_DELAY + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done;

  assign done = (cnt_q == CW'(RDY_DELAY));

  always_comb begin
    if (!act)      cnt_d = '0;
    else if (done) cnt_d = cnt_q;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign rdy = act && done;

  AST_RDY_LAGS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> ($past(act, 1) && $past(act, 2))) else $error("ready early"); // R7
endmodule

// File: rtl/host_reg_port.sv
module host_reg_port
  import host_reg_pkg::*;
#(
  parameter int NUM_REGS    = 32,
  parameter int RDY_DELAY   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       host_clk,
  input  logic       arst_n,
  input  logic       ds_style,
  input  logic [6:0] h_addr,
  input  logic       rd_or_rw,
  input  logic       wr_or_ds_n,
  input  logic       astb_n,
  input  logic [7:0] h_din,
  output logic [7:0] h_dout,
  output logic       h_doe,
  output logic       h_rdy
);
  localparam int BUN_W = 3 + ADDR_W + DATA_W;
  localparam logic [BUN_W-1:0] BUN_RST = {3'b111, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};

  logic rst_q1, rst_q2, rst_n_i;

  always_ff @(posedge host_clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end
  assign rst_n_i = rst_q2;

  logic [BUN_W-1:0] bun_raw, bun_s;
  logic   astb_s, wrds_s, rdrw_s;
  haddr_t addr_s;
  hdata_t din_s;

  assign bun_raw = {astb_n, wr_or_ds_n, rd_or_rw, h_addr, h_din};

  host_sync #(.WIDTH(BUN_W), .STAGES(SYNC_STAGES), .RST_VAL(BUN_RST)) u_sync (
    .clk   (host_clk),
    .rst_n (rst_n_i),
    .d     (bun_raw),
    .q     (bun_s)
  );

  assign {astb_s, wrds_s, rdrw_s, addr_s, din_s} = bun_s;

  bus_style_e style;
  logic rd_act, wr_act, wr_pulse;

  assign style = bus_style_e'(ds_style);

  host_strobe_decode u_dec (
    .clk      (host_clk),
    .rst_n    (rst_n_i),
    .style    (style),
    .rdrw_s   (rdrw_s),
    .wrds_s   (wrds_s),
    .astb_s   (astb_s),
    .rd_act   (rd_act),
    .wr_act   (wr_act),
    .wr_pulse (wr_pulse)
  );

  hdata_t rdata;

  host_reg_file #(.NUM_REGS(NUM_REGS)) u_rf (
    .clk   (host_clk),
    .rst_n (rst_n_i),
    .wr_en (wr_pulse),
    .addr  (addr_s),
    .wdata (din_s),
    .rdata (rdata)
  );

  host_ready_gen #(.RDY_DELAY(RDY_DELAY)) u_rdy (
    .clk   (host_clk),
    .rst_n (rst_n_i),
    .act   (rd_act | wr_act),
    .rdy   (h_rdy)
  );

  assign h_doe  = rd_act;
  assign h_dout = rd_act ? rdata : '0;

  AST_RDY_IN_CYCLE: assert property (@(posedge host_clk) disable iff (!rst_n_i)
    h_rdy |-> (h_doe || wr_act)) else $error("ready outside access"); // R7

  AST_DRIVE_BEFORE_RDY: assert property (@(posedge host_clk) disable iff (!rst_n_i)
    $rose(h_doe) |-> !$past(h_rdy)) else $error("ready before drive"); // R6
endmodule

// File: tb/tb_host_reg_port.sv
`timescale 1ns/1ps
module tb_host_reg_port;
  localparam int NREG = 32;

  logic       clk = 1'b0;
  logic       arst_n;
  logic       ds_style;
  logic [6:0] h_addr;
  logic       rd_or_rw;
  logic       wr_or_ds_n;
  logic       astb_n;
  logic [7:0] h_din;
  logic [7:0] h_dout;
  logic       h_doe;
  logic       h_rdy;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;
  logic [7:0] model [128];

  always #2.5 clk = ~clk;

  host_reg_port dut (
    .host_clk (clk),
    .arst_n   (arst_n),
    .ds_style (ds_style),
    .h_addr   (h_addr),
    .rd_or_rw (rd_or_rw),
    .wr_or_ds_n (wr_or_ds_n),
    .astb_n   (astb_n),
    .h_din    (h_din),
    .h_dout   (h_dout),
    .h_doe    (h_doe),
    .h_rdy    (h_rdy)
  );

  function automatic logic [7:0] exp_rd(int a);
    return (a < NREG) ? model[a] : 8'h00;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // R3: in style 1, rd_or_rw low selects a write
  task automatic do_write(bit style, int a, logic [7:0] d);
    h_addr = 7'(a);
    h_din  = d;
    if (style) begin rd_or_rw = 1'b0; astb_n = 1'b0; end
    idle(3);
    wr_or_ds_n = 1'b0;
    idle(4);
    check(h_doe == 1'b0, "R6", "oe during write", h_doe, 0);
    wr_or_ds_n = 1'b1;
    idle(4);
    astb_n   = 1'b1;
    rd_or_rw = 1'b1;
    idle(2);
    if (a < NREG) model[a] = d;
  endtask

  task automatic do_read(bit style, int a, string req);
    logic [7:0] e;
    e = exp_rd(a);
    h_addr = 7'(a);
    if (style) begin rd_or_rw = 1'b1; astb_n = 1'b0; end
    idle(3);
    if (style) wr_or_ds_n = 1'b0; else rd_or_rw = 1'b0;
    idle(1);
    check(h_doe == 1'b0, "R1", "oe after one edge", h_doe, 0);
    idle(1);
    check(h_doe == 1'b1, req, "oe after two edges", h_doe, 1);
    check(h_dout == e, req, "read data", h_dout, e);
    idle(1);
    check(h_rdy == 1'b0, "R7", "rdy after three edges", h_rdy, 0);
    idle(1);
    check(h_rdy == 1'b1, "R7", "rdy after four edges", h_rdy, 1);
    check(h_dout == e, req, "read data held", h_dout, e);
    if (style) wr_or_ds_n = 1'b1; else rd_or_rw = 1'b1;
    idle(1);
    check(h_doe == 1'b1, "R6", "oe one edge after release", h_doe, 1);
    idle(1);
    check(h_doe == 1'b0, "R6", "oe released", h_doe, 0);
    check(h_dout == 8'h00, "R6", "dout quiet", h_dout, 0);
    check(h_rdy == 1'b0, "R7", "rdy released", h_rdy, 0);
    astb_n   = 1'b1;
    rd_or_rw = 1'b1;
    idle(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    arst_n = 1'b0; ds_style = 1'b0; h_addr = '0; h_din = '0;
    rd_or_rw = 1'b1; wr_or_ds_n = 1'b1; astb_n = 1'b1;
    idle(5);
    arst_n = 1'b1;
    idle(4);
    // R9 reset state
    check(h_doe == 1'b0, "R9", "oe after reset", h_doe, 0);
    check(h_rdy == 1'b0, "R9", "rdy after reset", h_rdy, 0);
    do_read(0, 5, "R9");
    do_read(0, 31, "R9");

    // split style directed
    do_write(0, 31, 8'hA5);
    do_read(0, 31, "R2");
    do_write(0, 32, 8'h5A);
    do_read(0, 32, "R8");
    do_write(0, 100, 8'hFF);
    do_read(0, 100, "R8");
    do_read(0, 4, "R8");
    do_write(0, 0, 8'h3C);
    do_read(0, 0, "R1");

    for (int n = 0; n < 150; n++) begin
      int a;
      logic [7:0] d;
      a = ($urandom % 2) ? int'($urandom % NREG) : int'($urandom % 128);
      d = 8'($urandom);
      if ($urandom % 2) do_write(0, a, d);
      else              do_read(0, a, "R2");
    end

    // data-strobe style
    idle(4);
    ds_style = 1'b1;
    idle(4);
    do_write(1, 7, 8'hC3);
    do_read(1, 7, "R4");
    do_read(1, 31, "R3 R5");

    // R5: data strobe with address strobe high does nothing
    h_addr = 7'd7; h_din = 8'h11; rd_or_rw = 1'b0; astb_n = 1'b1;
    idle(3);
    wr_or_ds_n = 1'b0;
    idle(4);
    check(h_doe == 1'b0, "R5", "no drive with astb high", h_doe, 0);
    check(h_rdy == 1'b0, "R5", "no ready with astb high", h_rdy, 0);
    rd_or_rw = 1'b1;
    idle(4);
    check(h_doe == 1'b0, "R5", "no read drive with astb high", h_doe, 0);
    wr_or_ds_n = 1'b1;
    idle(4);
    do_read(1, 7, "R5");

    do_write(1, 64, 8'h77);
    do_read(1, 64, "R8");

    for (int n = 0; n < 150; n++) begin
      int a;
      logic [7:0] d;
      a = ($urandom % 2) ? int'($urandom % NREG) : int'($urandom % 128);
      d = 8'($urandom);
      if ($urandom % 2) do_write(1, a, d);
      else              do_read(1, a, "R4");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule